// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block turns a two-part logical address (an 18-bit segment number and a 16-bit offset) into a physical address. Every segment is paged in 1 KiB units. The block works out the address of a segment descriptor from a table base input and the segment number, then fetches that descriptor. It checks the offset against the segment's largest legal offset. If the offset is in range, it fetches one page-table word from the segment's own page table and joins the frame number to the low 10 offset bits.

Table words come from a single read port with variable latency. Only one read is outstanding at any time. A request is accepted only when the block is idle. Every accepted request produces exactly one response, which carries either a physical address or a fault code. Two conditions give separate faults: an offset beyond the segment limit, and an unusable page entry.

Top module: `pseg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_req` are 0.
- R2: The first read of a translation goes to word address `tbl_base + seg`. The segment number is zero-extended to 24 bits.
- R3: A descriptor word is laid out as bits [39:24], the largest legal offset, and bits [23:0], the page-table base. An offset greater than the largest legal offset gives `rsp_fault` = 1 (limit fault). In that case no page-table read is made, so the translation uses exactly one read.
- R4: When the offset is within the limit, the second read goes to `page-table base + offset[15:10]`.
- R5: A page word is usable when bit 39 is 1 and bits [38:14] are all 0. A usable word gives `rsp_fault` = 0 and `rsp_paddr` = {word[13:0], offset[9:0]}.
- R6: An unusable page word gives `rsp_fault` = 2 (page fault) and `rsp_paddr` = 0.
- R7: `mem_req` never rises while an earlier read is still waiting for `mem_rvalid`. A translation that passes the limit check makes exactly two reads.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the response has been given. A `req_valid` raised in that time is ignored and does not change the result.
- R9: Each accepted request gives a `rsp_valid` pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 24 | Word address of segment descriptor 0, sampled when a request is accepted |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_seg | input | 18 | Segment number |
| req_off | input | 16 | Offset within the segment |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 24 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 40 | Read data word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 limit fault, 2 page fault |

## Verification
The assertions check, on every cycle, the properties that are about timing and counts. These are: the single outstanding read, the one-cycle response pulse, the drop of ready after acceptance, the read count for each kind of outcome (one read for a limit fault, two otherwise), and a zero address with a page fault. The correctness of the data can only be shown by the bench scenarios. This covers the descriptor and page-entry addresses, the joined physical address, the limit boundary at exactly the maximum offset and one above it, the reserved-bit rule, and the fact that requests raised while busy have no effect. The bench checks these against a memory whose contents are computed by formula, with read latencies of one to three cycles.

// File: rtl/pseg_pkg.sv
package pseg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSEG,
    ST_CHECK,
    ST_RPAGE,
    ST_RESP
  } pseg_state_t;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_LEN  = 2'd1;
  localparam logic [1:0] FLT_PAGE = 2'd2;
endpackage

// File: rtl/pseg_limit_chk.sv
module pseg_limit_chk #(
  parameter int LIM_W = 16
) (
  input  logic [LIM_W-1:0] off,
  input  logic [LIM_W-1:0] max_off,
  output logic             in_range
);
  always_comb in_range = (off <= max_off);
endmodule

// File: rtl/pseg_addr_gen.sv
module pseg_addr_gen #(
  parameter int SEG_W = 18,
  parameter int PG_W  = 6,
  parameter int AW    = 24
) (
  input  logic [AW-1:0]    tbl_base,
  input  logic [SEG_W-1:0] seg,
  input  logic [AW-1:0]    pt_base,
  input  logic [PG_W-1:0]  page,
  output logic [AW-1:0]    desc_addr,
  output logic [AW-1:0]    pte_addr
);
  always_comb begin
    desc_addr = tbl_base + AW'(seg);
    pte_addr  = pt_base + AW'(page);
  end
endmodule

// File: rtl/pseg_ctrl.sv
module pseg_ctrl
  import pseg_pkg::*;
#(
  parameter int PG_W    = 6,
  parameter int OFF_W   = 10,
  parameter int AW      = 24,
  parameter int FRAME_W = 14,
  localparam int LIM_W  = PG_W + OFF_W,
  localparam int DW     = LIM_W + AW,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIM_W-1:0] req_off,
  input  logic [AW-1:0]    desc_addr,
  input  logic [AW-1:0]    pte_addr,
  input  logic             in_range,
  output logic [LIM_W-1:0] off_q,
  output logic [LIM_W-1:0] lim_q,
  output logic [AW-1:0]    ptb_q,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  pseg_state_t st;
  logic        pte_ok;

  always_comb begin
    req_ready = (st == ST_IDLE);
    pte_ok    = mem_rdata[DW-1] && (mem_rdata[DW-2:FRAME_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      off_q     <= '0;
      lim_q     <= '0;
      ptb_q     <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          off_q    <= req_off;
          mem_req  <= 1'b1;
          mem_addr <= desc_addr;
          st       <= ST_RSEG;
        end
        ST_RSEG: if (mem_rvalid) begin
          lim_q <= mem_rdata[DW-1:AW];
          ptb_q <= mem_rdata[AW-1:0];
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (in_range) begin
            mem_req  <= 1'b1;
            mem_addr <= pte_addr;
            st       <= ST_RPAGE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= FLT_LEN;
            rsp_paddr <= '0;
            st        <= ST_RESP;
          end
        end
        ST_RPAGE: if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          if (pte_ok) begin
            rsp_fault <= FLT_NONE;
            rsp_paddr <= {mem_rdata[FRAME_W-1:0], off_q[OFF_W-1:0]};
          end else begin
            rsp_fault <= FLT_PAGE;
            rsp_paddr <= '0;
          end
          st <= ST_RESP;
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pseg_xlate.sv
module pseg_xlate #(
  parameter int SEG_W   = 18,
  parameter int PG_W    = 6,
  parameter int OFF_W   = 10,
  parameter int AW      = 24,
  parameter int FRAME_W = 14,
  localparam int LIM_W  = PG_W + OFF_W,
  localparam int DW     = LIM_W + AW,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [LIM_W-1:0] req_off,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  logic [AW-1:0]    desc_addr, pte_addr, ptb_q;
  logic [LIM_W-1:0] off_q, lim_q;
  logic             in_range;

  pseg_addr_gen #(.SEG_W(SEG_W), .PG_W(PG_W), .AW(AW)) u_addr (
    .tbl_base (tbl_base),
    .seg      (req_seg),
    .pt_base  (ptb_q),
    .page     (off_q[LIM_W-1:OFF_W]),
    .desc_addr(desc_addr),
    .pte_addr (pte_addr)
  );

  pseg_limit_chk #(.LIM_W(LIM_W)) u_lim (
    .off     (off_q),
    .max_off (lim_q),
    .in_range(in_range)
  );

  pseg_ctrl #(.PG_W(PG_W), .OFF_W(OFF_W), .AW(AW), .FRAME_W(FRAME_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_off),
    .desc_addr (desc_addr),
    .pte_addr  (pte_addr),
    .in_range  (in_range),
    .off_q     (off_q),
    .lim_q     (lim_q),
    .ptb_q     (ptb_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
  );
endmodule

// File: rtl/pseg_xlate_chk.sv
module pseg_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  logic       pending;
  logic [1:0] nreads;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      nreads  <= '0;
    end else begin
      if (mem_req) pending <= 1'b1;
      else if (mem_rvalid) pending <= 1'b0;
      if (req_valid && req_ready) nreads <= '0;
      else if (mem_req && nreads != 2'd3) nreads <= nreads + 2'd1;
    end
  end

  // R7
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pending);

  // R7
  two_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd1) |-> nreads == 2'd2);

  // R3
  len_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd1) |-> nreads == 2'd1);

  // R6
  page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd2) |-> rsp_paddr == '0);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind pseg_xlate pseg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_rvalid(mem_rvalid),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault)
);

// File: tb/pseg_xlate_bench.sv
module pseg_xlate_bench;
  localparam logic [23:0] STBR  = 24'h100000;
  localparam logic [23:0] PTREG = 24'h800000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] tbl_base = STBR;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [39:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int tests = 0, fails = 0;
  int lat = 1;
  int rd_n = 0;
  logic [23:0] rd_last = '0, rd_prev = '0, ma = '0;
  int  cnt = 0;
  bit  mbusy = 0;

  always #10 clk = ~clk;

  pseg_xlate u_pseg_xlate (
    .clk(clk), .rst(rst), .tbl_base(tbl_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [15:0] max_off(input logic [17:0] s);
    if (s[2:0] == 3'd5) return 16'hFFFF;
    return 16'(s[2:0]) * 16'd9000 + 16'd1000;
  endfunction

  function automatic logic [39:0] mem_word(input logic [23:0] a);
    logic [23:0] idx;
    logic [11:0] s;
    logic [5:0]  p;
    logic [13:0] fr;
    logic        v;
    logic [24:0] rsv;
    if (a >= PTREG) begin
      idx = a - PTREG;
      s   = idx[17:6];
      p   = idx[5:0];
      v   = ((int'(p) + int'(s)) % 5) != 0;
      fr  = {s[7:0], p} ^ 14'h155;
      rsv = (s == 12'hFFF) ? 25'h10 : '0;
      return {v, rsv, fr};
    end
    idx = a - STBR;
    return {max_off(idx[17:0]), PTREG | {6'b0, idx[11:0], 6'b0}};
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) mbusy <= 0;
    else if (mem_req) begin
      mbusy <= 1; cnt <= lat; ma <= mem_addr;
      rd_prev <= rd_last; rd_last <= mem_addr; rd_n <= rd_n + 1;
    end else if (mbusy) begin
      if (cnt <= 1) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem_word(ma); mbusy <= 0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic check(input string name, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", name, act, exp);
    end
  endtask

  task automatic xlate(input logic [17:0] s, input logic [15:0] o, input bit noise);
    int start;
    logic [23:0] da, pa, ptb, exp_pa;
    logic [39:0] w;
    logic [1:0]  ef;
    bit ok;
    @(negedge clk);
    start = rd_n;
    req_seg = s; req_off = o; req_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      req_seg = ~s; req_off = ~o;
    end else req_valid = 1'b0;
    while (!rsp_valid) begin
      if (noise) check("R8 ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    da  = STBR + {6'b0, s};
    ptb = mem_word(da)[23:0];
    pa  = ptb + {18'b0, o[15:10]};
    if (o > max_off(s)) begin
      ef = 2'd1; exp_pa = '0;
    end else begin
      w  = mem_word(pa);
      ok = w[39] && (w[38:14] == '0);
      ef = ok ? 2'd0 : 2'd2;
      exp_pa = ok ? {w[13:0], o[9:0]} : 24'h0;
    end
    check("R3 R5 R6 fault code", 32'(rsp_fault), 32'(ef));
    check("R5 R6 physical address", 32'(rsp_paddr), 32'(exp_pa));
    if (ef == 2'd1) begin
      check("R3 single read", 32'(rd_n - start), 32'd1);
      check("R2 descriptor address", 32'(rd_last), 32'(da));
    end else begin
      check("R7 two reads", 32'(rd_n - start), 32'd2);
      check("R2 descriptor address", 32'(rd_prev), 32'(da));
      check("R4 page entry address", 32'(rd_last), 32'(pa));
    end
    @(negedge clk);
    check("R9 one-cycle response", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [17:0] segs [8];
    int n;
    segs = '{18'd0, 18'd1, 18'd2, 18'd5, 18'd7, 18'h3FFFF, 18'h12345, 18'h00FFF};
    repeat (3) @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 no response after reset", 32'(rsp_valid), 32'd0);
    check("R1 no read after reset", 32'(mem_req), 32'd0);
    rst = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 64; p++) begin
        lat = 1 + (n % 3); n++;
        xlate(segs[i], 16'(p * 1024) + 16'((p * 37 + int'(segs[i])) & 1023), 1'b0);
      end
      lat = 2;
      xlate(segs[i], max_off(segs[i]), 1'b0);
      if (max_off(segs[i]) != 16'hFFFF) xlate(segs[i], max_off(segs[i]) + 16'd1, 1'b0);
      xlate(segs[i], 16'h0000, 1'b0);
      xlate(segs[i], 16'hFFFF, 1'b0);
    end
    lat = 3;
    xlate(18'd3, 16'h0C21, 1'b1);
    xlate(18'd0, 16'hF000, 1'b1);
    @(negedge clk);
    check("R8 ready restored", 32'(req_ready), 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule